// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a small processor core. A subroutine call and an interrupt entry are handled the same way: each pushes the address to return to. A return from a subroutine or from an interrupt pops it. The stack is a short chain of registers that shift as a group. It has no stack pointer, and it does not flag an overflow or an underflow.

A push puts the new address in the top level and moves every older entry one level deeper. The entry that was in the deepest level is lost. A pop moves every entry one level up, and the deepest level keeps its value. If there are more pops than stored entries, the deepest address is therefore returned again. The top level drives the output directly from a register. The returning address is on the output in the same cycle that the pop strobe is raised.

Top module: `rasx_stack`

## Requirements
- R1: While `rst` is high at a rising clock edge, every level is cleared, so `tos_o` reads 0 after that edge.
- R2: A push (`push_i`=1) stores `push_addr_i` in the top level and moves each older level one deeper. `tos_o` shows the new address after the edge.
- R3: A pop without a push (`pop_i`=1, `push_i`=0) moves each level one step toward the top. After the edge, `tos_o` shows the value that was one level below the top.
- R4: On a pop, the deepest level keeps its value. After pushes of A1, A2, A3 and A4, four pops return A4, A3, A2 and then A2 again.
- R5: With the default depth of three, a fourth push with no pop in between discards the oldest address. Later pops return only the three newest addresses.
- R6: When `push_i` and `pop_i` are both 1 in the same cycle, the push is carried out and the pop is ignored. The result is the same as a push alone.
- R7: With both strobes low, all levels hold their values, so `tos_o` does not change.
- R8: `tos_o` is the top level taken directly from its register. It does not depend on `pop_i`, so the return address can be read in the cycle the pop is raised, before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe, raised for a call or an interrupt entry |
| push_addr_i | input | 9 | Return address to store on a push |
| pop_i | input | 1 | Pop strobe, raised for a return |
| tos_o | output | 9 | Current top-of-stack return address |

## Verification
A push and a pop can fall in the same cycle. This happens when an interrupt is taken just as a return is being decoded. The bench raises both strobes together with different stack contents: once when the stack is full, and once right after an underflow has left repeated values in the levels. After that cycle, the top must show the pushed address. The pops that follow must return the pushed address, then the entries pushed down below it, exactly as for a push alone.

// File: rtl/rasx_pkg.sv
package rasx_pkg;
  typedef enum logic [1:0] {
    SH_HOLD = 2'd0,
    SH_DOWN = 2'd1,
    SH_UP   = 2'd2
  } shift_e;
endpackage

// File: rtl/rasx_op_decode.sv
module rasx_op_decode
  import rasx_pkg::*;
(
  input  logic   push_i,
  input  logic   pop_i,
  output shift_e shift_o
);
  // a push wins over a pop in the same cycle
  always_comb begin
    if (push_i)     shift_o = SH_DOWN;
    else if (pop_i) shift_o = SH_UP;
    else            shift_o = SH_HOLD;
  end
endmodule

// File: rtl/rasx_level.sv
module rasx_level
  import rasx_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  shift_e           shift_i,
  input  logic [WIDTH-1:0] from_above_i,
  input  logic [WIDTH-1:0] from_below_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      unique case (shift_i)
        SH_DOWN: q_o <= from_above_i;
        SH_UP:   q_o <= from_below_i;
        default: q_o <= q_o;
      endcase
    end
  end

  assert_level_reset_R1: assert property (@(posedge clk) rst |=> q_o == '0);
endmodule

// File: rtl/rasx_stack.sv
module rasx_stack
  import rasx_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_addr_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] tos_o
);
  localparam int LAST = DEPTH - 1;

  shift_e           shift;
  logic [WIDTH-1:0] lvl [DEPTH];

  rasx_op_decode u_dec (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .shift_o (shift)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [WIDTH-1:0] above;
    logic [WIDTH-1:0] below;
    if (g == 0) begin : g_top
      assign above = push_addr_i;
    end else begin : g_mid
      assign above = lvl[g-1];
    end
    if (g == LAST) begin : g_deep
      assign below = lvl[g];   // deepest level keeps its contents on a pop
    end else begin : g_up
      assign below = lvl[g+1];
    end
    rasx_level #(.WIDTH(WIDTH)) u_lvl (
      .clk          (clk),
      .rst          (rst),
      .shift_i      (shift),
      .from_above_i (above),
      .from_below_i (below),
      .q_o          (lvl[g])
    );
  end

  assign tos_o = lvl[0];

  assert_reset_R1: assert property (@(posedge clk) rst |=> tos_o == '0);
  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    push_i |=> tos_o == $past(push_addr_i));
  assert_push_shift_R2: assert property (@(posedge clk) disable iff (rst)
    push_i |=> lvl[1] == $past(tos_o));
  assert_pop_top_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> tos_o == $past(lvl[1]));
  assert_pop_deep_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> lvl[LAST] == $past(lvl[LAST]));
  assert_overflow_drop_R5: assert property (@(posedge clk) disable iff (rst)
    push_i |=> lvl[LAST] == $past(lvl[LAST-1]));
  assert_push_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> (tos_o == $past(push_addr_i) && lvl[1] == $past(tos_o)));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> ($stable(tos_o) && $stable(lvl[LAST])));
endmodule

// File: tb/sim_rasx_stack.sv
module sim_rasx_stack;
  localparam int W = 9;
  localparam int D = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push = 1'b0;
  logic         pop = 1'b0;
  logic [W-1:0] addr = '0;
  logic [W-1:0] tos;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model [D];

  always #2.5 clk = ~clk;

  rasx_stack #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .push_i(push), .push_addr_i(addr),
    .pop_i(pop), .tos_o(tos)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check R8 before edge, check after edge
  task automatic step(input logic pu, input logic po, input logic [W-1:0] a, input string req);
    push = pu; pop = po; addr = a;
    #1 check("R8", tos, model[0]);
    @(posedge clk);
    if (pu) begin
      for (int i = D-1; i > 0; i--) model[i] = model[i-1];
      model[0] = a;
    end else if (po) begin
      for (int i = 0; i < D-1; i++) model[i] = model[i+1];
    end
    @(negedge clk);
    check(req, tos, model[0]);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < D; i++) model[i] = '0;
    check("R1", tos, '0);
  endtask

  task automatic t_basic();
    do_reset();
    step(1, 0, 9'h011, "R2");
    step(1, 0, 9'h022, "R2");
    step(0, 0, 9'h1FF, "R7");
    step(0, 0, 9'h000, "R7");
    step(0, 1, 9'h000, "R3");
    step(0, 1, 9'h000, "R3");
  endtask

  task automatic t_four_pushes();
    do_reset();
    step(1, 0, 9'h0A1, "R2");
    step(1, 0, 9'h0A2, "R2");
    step(1, 0, 9'h0A3, "R2");
    step(1, 0, 9'h0A4, "R5");
    step(0, 1, 0, "R4"); check("R4", tos, 9'h0A3);
    step(0, 1, 0, "R4"); check("R4", tos, 9'h0A2);
    step(0, 1, 0, "R4"); check("R4", tos, 9'h0A2);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 6; i++) step(1, 0, W'(9'h100 + i), "R5");
    step(0, 1, 0, "R5"); check("R5", tos, 9'h105);
    step(0, 1, 0, "R5"); check("R5", tos, 9'h104);
    step(0, 1, 0, "R5"); check("R5", tos, 9'h104);
  endtask

  task automatic t_underflow();
    do_reset();
    step(1, 0, 9'h055, "R2");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R4");
    check("R4", tos, 9'h000);
    step(1, 0, 9'h1C3, "R2");
    step(1, 1, 9'h0B0, "R6");
    step(0, 1, 0, "R6"); check("R6", tos, 9'h1C3);
  endtask

  task automatic t_alternate();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1, 0, W'(i * 37 + 5), "R2");
      step(1, 0, W'(i * 11 + 200), "R2");
      step(0, 1, 0, "R3");
    end
  endtask

  task automatic t_simultaneous();
    do_reset();
    step(1, 0, 9'h001, "R2");
    step(1, 0, 9'h002, "R2");
    step(1, 0, 9'h003, "R2");
    step(1, 1, 9'h1AA, "R6");
    check("R6", tos, 9'h1AA);
    step(0, 1, 0, "R6"); check("R6", tos, 9'h003);
    step(0, 1, 0, "R6"); check("R6", tos, 9'h002);
    step(0, 1, 0, "R4");
  endtask

  initial begin
    @(negedge clk);
    t_basic();
    t_four_pushes();
    t_overflow();
    t_underflow();
    t_alternate();
    t_simultaneous();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule